// File: doc/BRIEF.md
# Soft-Start Off-Time Sequencer

This block governs the off-time of a constant-off-time buck converter while it starts up. On a start pulse it loads an internal soft-start off-time with the longest permitted off-time. The value is then lowered once per switching cycle. The step is large while the inductor current still falls to zero in every cycle (discontinuous mode). The step becomes small from the first cycle in which no zero crossing is seen, which means continuous conduction has been reached. When the soft-start value reaches zero, control passes entirely to the feedback loop.

The off-time that the block drives out is the larger of the soft-start value and the off-time requested by feedback, clamped between a minimum and a maximum. Early in start-up the soft-start value is the larger of the two and governs the off-time. Later the feedback value takes over. A phase output reports which stage is active.

Top module: `soft_start_seq`

## Requirements
- R1: After reset the phase output reads fast (code 0) and the soft-start value equals TOFF_MAX.
- R2: A start pulse reloads the soft-start value with TOFF_MAX and sets the phase to fast, from any phase. It takes priority over a cycle-end strobe in the same clock.
- R3: In the fast phase, each cycle-end strobe with the zero-current flag set lowers the soft-start value by STEP_FAST, saturating at zero. Clocks without a strobe leave the value and the phase unchanged.
- R4: In the fast phase, a cycle-end strobe with the zero-current flag clear moves the phase to slow (code 1) and lowers the value by STEP_SLOW.
- R5: In the slow phase, each cycle-end strobe lowers the value by STEP_SLOW whatever the zero-current flag shows. The phase never returns to fast without a start pulse.
- R6: When the soft-start value reaches zero, in either ramp phase, the phase becomes steady (code 2). It stays steady until a start pulse.
- R7: toff_o equals the larger of the soft-start value and fb_toff_i, clamped to the range [TOFF_MIN, TOFF_MAX]. It follows fb_toff_i within the same clock.
- R8: The phase codes are fast = 0, slow = 1 and steady = 2. The code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse (standby exit or auto-restart) |
| zcd_i | input | 1 | Zero-current crossing seen in the cycle that is ending |
| cyc_end_i | input | 1 | One-clock strobe marking the end of a switching cycle |
| fb_toff_i | input | TOFF_W | Off-time requested by the feedback loop |
| toff_o | output | TOFF_W | Effective off-time |
| phase_o | output | 2 | Phase: 0 fast, 1 slow, 2 steady |

## Verification
The soft-start value cannot be read directly. It is observed through toff_o with the feedback input held at zero, so every reading above TOFF_MIN shows the internal value exactly. The hardest state to reach is the point where the value hits zero. The slow path needs well over a thousand strobes to get there, so the bench drives long strobe trains and follows them with a model kept alongside. The fast path to zero only occurs when the zero-current flag stays set for the whole ramp, and a separate scenario holds it set to exercise saturation at zero.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    PH_FAST   = 2'd0,
    PH_SLOW   = 2'd1,
    PH_STEADY = 2'd2
  } ss_phase_e;
endpackage

// File: rtl/ss_ramp.sv
module ss_ramp
  import ss_pkg::*;
#(
  parameter int TOFF_W    = 16,
  parameter int TOFF_MAX  = 26000,
  parameter int STEP_FAST = 256,
  parameter int STEP_SLOW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              zcd_i,
  input  logic              cyc_end_i,
  output logic [TOFF_W-1:0] ss_o,
  output ss_phase_e         phase_o
);
  localparam logic [TOFF_W-1:0] MaxV  = TOFF_W'(TOFF_MAX);
  localparam logic [TOFF_W-1:0] FastV = TOFF_W'(STEP_FAST);
  localparam logic [TOFF_W-1:0] SlowV = TOFF_W'(STEP_SLOW);

  logic [TOFF_W-1:0] ss_q, ss_d, step;
  ss_phase_e         ph_q, ph_d;
  logic              use_fast;

  // fast step only while DCM persists in the fast phase
  assign use_fast = (ph_q == PH_FAST) && zcd_i;
  assign step     = use_fast ? FastV : SlowV;

  always_comb begin
    ss_d = ss_q;
    ph_d = ph_q;
    if (start_i) begin
      ss_d = MaxV;
      ph_d = PH_FAST;
    end else if (cyc_end_i && ph_q != PH_STEADY) begin
      ss_d = (ss_q > step) ? ss_q - step : '0;
      if (ss_d == '0)       ph_d = PH_STEADY;
      else if (!use_fast)   ph_d = PH_SLOW;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_q <= MaxV;
      ph_q <= PH_FAST;
    end else begin
      ss_q <= ss_d;
      ph_q <= ph_d;
    end
  end

  assign ss_o    = ss_q;
  assign phase_o = ph_q;

  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ss_q == MaxV && ph_q == PH_FAST)); // R2
  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !cyc_end_i) |=> ($stable(ss_q) && $stable(ph_q))); // R3
  AST_MONOTONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ss_q <= $past(ss_q)); // R3
  AST_NO_REFAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != PH_FAST && !start_i) |=> ph_q != PH_FAST); // R5
  AST_STEADY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_STEADY |-> ss_q == '0); // R6
  AST_PHASE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q != 2'd3); // R8
endmodule

// File: rtl/ss_toff_merge.sv
module ss_toff_merge #(
  parameter int TOFF_W   = 16,
  parameter int TOFF_MIN = 17,
  parameter int TOFF_MAX = 26000
) (
  input  logic [TOFF_W-1:0] ss_i,
  input  logic [TOFF_W-1:0] fb_i,
  output logic [TOFF_W-1:0] toff_o
);
  localparam logic [TOFF_W-1:0] MinV = TOFF_W'(TOFF_MIN);
  localparam logic [TOFF_W-1:0] MaxV = TOFF_W'(TOFF_MAX);

  logic [TOFF_W-1:0] big;

  always_comb begin
    big = (ss_i > fb_i) ? ss_i : fb_i;
    if (big > MaxV)      toff_o = MaxV;
    else if (big < MinV) toff_o = MinV;
    else                 toff_o = big;
  end

  always_comb begin
    AST_TOFF_BOUNDS: assert (toff_o >= MinV && toff_o <= MaxV); // R7
  end
endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq
  import ss_pkg::*;
#(
  parameter int TOFF_W    = 16,
  parameter int TOFF_MIN  = 17,
  parameter int TOFF_MAX  = 26000,
  parameter int STEP_FAST = 256,
  parameter int STEP_SLOW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              zcd_i,
  input  logic              cyc_end_i,
  input  logic [TOFF_W-1:0] fb_toff_i,
  output logic [TOFF_W-1:0] toff_o,
  output logic [1:0]        phase_o
);
  logic [TOFF_W-1:0] ss_val;
  ss_phase_e         phase;

  ss_ramp #(
    .TOFF_W(TOFF_W), .TOFF_MAX(TOFF_MAX),
    .STEP_FAST(STEP_FAST), .STEP_SLOW(STEP_SLOW)
  ) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .zcd_i(zcd_i),
    .cyc_end_i(cyc_end_i), .ss_o(ss_val), .phase_o(phase)
  );

  ss_toff_merge #(
    .TOFF_W(TOFF_W), .TOFF_MIN(TOFF_MIN), .TOFF_MAX(TOFF_MAX)
  ) u_merge (
    .ss_i(ss_val), .fb_i(fb_toff_i), .toff_o(toff_o)
  );

  assign phase_o = phase;

  AST_STEADY_FOLLOWS_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2 && fb_toff_i >= TOFF_W'(TOFF_MIN) && fb_toff_i <= TOFF_W'(TOFF_MAX))
      |-> toff_o == fb_toff_i); // R7
endmodule

// File: tb/soft_start_seq_tb.sv
module soft_start_seq_tb;
  localparam int W = 16, MINV = 17, MAXV = 26000, SF = 256, SS = 16;

  logic clk = 0, rst_n = 0, start = 0, zcd = 0, cyc = 0;
  logic [W-1:0] fb = '0;
  logic [W-1:0] toff;
  logic [1:0]   ph;
  int checks = 0, fails = 0;
  int m_ss, m_ph;
  bit done = 0;

  always #2.5 clk = ~clk;

  soft_start_seq #(.TOFF_W(W), .TOFF_MIN(MINV), .TOFF_MAX(MAXV),
                   .STEP_FAST(SF), .STEP_SLOW(SS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .zcd_i(zcd),
    .cyc_end_i(cyc), .fb_toff_i(fb), .toff_o(toff), .phase_o(ph));

  function automatic int exp_toff(int s, int f);
    int b = (s > f) ? s : f;
    if (b > MAXV) return MAXV;
    if (b < MINV) return MINV;
    return b;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk({req, " toff"}, int'(toff), exp_toff(m_ss, int'(fb)));
    chk({req, " phase"}, int'(ph), m_ph);
  endtask

  // model one strobe
  task automatic strobe(bit z);
    @(negedge clk); cyc = 1; zcd = z;
    @(negedge clk); cyc = 0; zcd = 0;
    if (m_ph != 2) begin
      int st = (m_ph == 0 && z) ? SF : SS;
      m_ss = (m_ss > st) ? m_ss - st : 0;
      if (m_ss == 0) m_ph = 2;
      else if (!(m_ph == 0 && z)) m_ph = 1;
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    m_ss = MAXV; m_ph = 0;
  endtask

  task automatic t_reset();
    m_ss = MAXV; m_ph = 0;
    chk_state("R1 reset");
    chk("R8 fast code", int'(ph), 0);
  endtask

  task automatic t_fast();
    do_start();
    for (int i = 0; i < 5; i++) strobe(1);
    chk_state("R3 fast ramp");
    repeat (6) @(negedge clk);
    chk_state("R3 hold without strobe");
  endtask

  task automatic t_slow();
    strobe(0);
    chk_state("R4 enter slow");
    chk("R8 slow code", int'(ph), 1);
    strobe(1);
    chk_state("R5 slow ignores zcd");
    fb = W'(MAXV - 100);
    #1;
    chk_state("R7 fb dominates");
    fb = 16'hFFFF;
    #1;
    chk_state("R7 clamp max");
    fb = '0;
  endtask

  task automatic t_restart_mid();
    do_start();
    chk_state("R2 start from slow");
    strobe(1); strobe(0);
    @(negedge clk); start = 1; cyc = 1; zcd = 1;
    @(negedge clk); start = 0; cyc = 0; zcd = 0;
    m_ss = MAXV; m_ph = 0;
    chk_state("R2 start beats strobe");
  endtask

  task automatic t_slow_to_zero();
    do_start();
    strobe(0);
    while (m_ph != 2) strobe(m_ss[0]);
    chk_state("R6 steady via slow");
    chk("R8 steady code", int'(ph), 2);
    strobe(0); strobe(1);
    chk_state("R6 stays steady");
    fb = 16'd500; #1;
    chk_state("R7 steady follows fb");
    fb = 16'd3; #1;
    chk_state("R7 clamp min");
    fb = '0;
  endtask

  task automatic t_fast_to_zero();
    do_start();
    while (m_ph != 2) strobe(1);
    chk_state("R6 steady via fast saturate");
    do_start();
    chk_state("R2 start from steady");
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fast();
        t_slow();
        t_restart_mid();
        t_slow_to_zero();
        t_fast_to_zero();
        done = 1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule